// File: doc/BRIEF.md
# Memory Refresh Scheduler with Low-Power Entry

This block paces auto-refresh for a synchronous DRAM. A free-running interval counter adds one owed refresh every `REF_WINDOW_CYC / ROW_COUNT` clocks, so that all rows are covered within the retention window. The memory advances its own row counter, so the block drives no address. Owed refreshes are held in a small saturating counter until the access controller hands over the command bus through a request/grant handshake. The block then asks for a precharge-all if any bank is still open. It issues the refresh command and drives NOP for the full refresh cycle time.

A low-power request routes the same handshake to self-refresh entry. That is the refresh command issued with CKE low, and it is allowed only once every bank is idle. While the memory sits in self-refresh, CKE stays low and the pins show NOP. When the request drops, CKE rises and NOP is held for an exit time before the bus is given back.

The controller is one state machine with eight named states: IDLE, REQ (bus requested), PRECH (waiting for precharge-all), AREF (refresh command), ARWAIT (NOP hold after refresh), SREN (self-refresh entry), SR (in self-refresh) and SRX (NOP hold after exit). Its transitions are:

- IDLE→REQ when a refresh is owed or low power is requested.
- REQ→PRECH when grant is high but a bank is open.
- PRECH→REQ once the banks are idle.
- REQ→SREN when grant is high, the banks are idle and low power is requested.
- REQ→AREF when grant is high, the banks are idle and only a refresh is owed.
- REQ→IDLE when grant is high and nothing is left to do.
- AREF→ARWAIT always.
- ARWAIT→REQ at the end of the hold if more work is pending; ARWAIT→IDLE otherwise.
- SREN→SR always.
- SR→SRX when the low-power request drops.
- SRX→IDLE at the end of the exit hold.

Top module: `refresh_sched`

## Requirements
- R1: One refresh becomes owed every REF_WINDOW_CYC/ROW_COUNT clocks after reset. With grant always given and the banks idle, successive refresh commands are exactly that many clocks apart.
- R2: `bus_req` rises when a refresh is owed or `lp_req` is high. Until `grant` arrives, the pins show deselect (`cs_n`=1) and CKE stays high. `bus_req` falls once the work is done.
- R3: When granted with `banks_idle` low, `pchg_req` is raised. No refresh or entry command appears until `banks_idle` is high.
- R4: The refresh command is `cs_n`=0, `ras_n`=0, `cas_n`=0, `we_n`=1 with CKE high.
- R5: After each refresh command, exactly RFC_CYC NOP cycles (`cs_n`=0, others 1) follow.
- R6: Owed refreshes accumulate up to DEBT_MAX and saturate there. Once granted, they are issued in a burst, one per 1+RFC_CYC+1 clocks.
- R7: With `lp_req` high, grant given and the banks idle, self-refresh entry (the refresh encoding with CKE low) is issued in preference to an owed refresh. Entry discards all owed refreshes.
- R8: While in self-refresh, CKE stays low and the pins show NOP until `lp_req` falls.
- R9: On exit, CKE rises and XSR_CYC NOP cycles with `busy` high follow. Then `busy` falls.
- R10: During reset, `bus_req`, `pchg_req` and `busy` are 0, CKE is 1 and the pins show deselect.
- R11: `busy` is high from the refresh or entry command through the end of its NOP hold. It is never high without `bus_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lp_req | input | 1 | Request to enter and stay in self-refresh |
| grant | input | 1 | Command bus handed to this block |
| banks_idle | input | 1 | All banks precharged |
| bus_req | output | 1 | Request for the command bus |
| pchg_req | output | 1 | Asks the access controller for precharge-all |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| cke | output | 1 | Clock enable |
| busy | output | 1 | Block is driving the command pins |

## Verification
The bench builds the block with a 400-clock window over 8 rows, which gives a 50-clock refresh interval. It uses RFC_CYC=4, XSR_CYC=6 and DEBT_MAX=3. The short interval makes counter expiry, debt saturation (three owed refreshes with a fourth arriving) and the back-to-back burst reachable within a few hundred clocks. The distinct hold lengths let the bench tell the refresh hold apart from the exit hold. The table scenarios mix grant delay, open banks and low-power entry, and directed tests cover burst spacing, the priority of low power and the discarding of debt.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_REQ,
        S_PRECH,
        S_AREF,
        S_ARWAIT,
        S_SREN,
        S_SR,
        S_SRX
    } state_e;

    typedef enum logic [1:0] {
        CMD_DESEL,
        CMD_NOP,
        CMD_AREF
    } cmd_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } pins_t;

    // Pin levels for each command; refresh is CS, RAS, CAS low with WE high.
    function automatic pins_t encode_cmd(cmd_e c);
        pins_t p;
        unique case (c)
            CMD_DESEL: p = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
            CMD_NOP:   p = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
            CMD_AREF:  p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
            default:   p = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
        endcase
        return p;
    endfunction

endpackage

// File: rtl/rfsh_pacer.sv
module rfsh_pacer #(
    parameter int unsigned TICK_CYC = 1562,
    parameter int unsigned DEBT_MAX = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic take_one,
    input  logic drop_all,
    output logic owed
);
    localparam int unsigned TICK_W = (TICK_CYC > 2) ? $clog2(TICK_CYC) : 1;
    localparam int unsigned DEBT_W = $clog2(DEBT_MAX + 1);

    logic [TICK_W-1:0] cnt;
    logic [DEBT_W-1:0] debt;
    logic              tick;

    assign tick = (cnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= TICK_W'(TICK_CYC - 1);
        end else if (tick) begin
            cnt <= TICK_W'(TICK_CYC - 1);
        end else begin
            cnt <= cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            debt <= '0;
        end else if (drop_all) begin
            debt <= '0;
        end else begin
            unique case ({tick, take_one})
                2'b10: if (debt != DEBT_W'(DEBT_MAX)) debt <= debt + 1'b1;
                2'b01: if (debt != '0) debt <= debt - 1'b1;
                default: debt <= debt;
            endcase
        end
    end

    assign owed = (debt != '0);

endmodule

// File: rtl/rfsh_hold_timer.sv
module rfsh_hold_timer #(
    parameter int unsigned CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
    import rfsh_pkg::*;
#(
    parameter int unsigned REF_WINDOW_CYC = 12_800_000,
    parameter int unsigned ROW_COUNT      = 8192,
    parameter int unsigned RFC_CYC        = 14,
    parameter int unsigned XSR_CYC        = 16,
    parameter int unsigned DEBT_MAX       = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lp_req,
    input  logic grant,
    input  logic banks_idle,
    output logic bus_req,
    output logic pchg_req,
    output logic cs_n,
    output logic ras_n,
    output logic cas_n,
    output logic we_n,
    output logic cke,
    output logic busy
);
    localparam int unsigned TICK_CYC = REF_WINDOW_CYC / ROW_COUNT;
    localparam int unsigned HOLD_MAX = (RFC_CYC > XSR_CYC) ? RFC_CYC : XSR_CYC;
    localparam int unsigned HOLD_W   = $clog2(HOLD_MAX + 1);

    state_e state, state_nx;
    cmd_e   cmd;
    pins_t  pins;

    logic              owed;
    logic              hold_done;
    logic              hold_load;
    logic [HOLD_W-1:0] hold_val;

    rfsh_pacer #(
        .TICK_CYC (TICK_CYC),
        .DEBT_MAX (DEBT_MAX)
    ) u_pacer (
        .clk      (clk),
        .rst_n    (rst_n),
        .take_one (state == S_AREF),
        .drop_all (state == S_SREN),
        .owed     (owed)
    );

    // One timer serves both NOP holds; it is armed on the way into the hold.
    assign hold_load = (state == S_AREF) || (state == S_SR && !lp_req);
    assign hold_val  = (state == S_AREF) ? HOLD_W'(RFC_CYC - 1) : HOLD_W'(XSR_CYC - 1);

    rfsh_hold_timer #(
        .CNT_W (HOLD_W)
    ) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (hold_load),
        .load_val (hold_val),
        .expired  (hold_done)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: begin
                if (owed || lp_req) state_nx = S_REQ;
            end
            S_REQ: begin
                if (grant) begin
                    if (!banks_idle)  state_nx = S_PRECH;
                    else if (lp_req)  state_nx = S_SREN;
                    else if (owed)    state_nx = S_AREF;
                    else              state_nx = S_IDLE;
                end
            end
            S_PRECH: begin
                if (banks_idle) state_nx = S_REQ;
            end
            S_AREF: begin
                state_nx = S_ARWAIT;
            end
            S_ARWAIT: begin
                if (hold_done) state_nx = (owed || lp_req) ? S_REQ : S_IDLE;
            end
            S_SREN: begin
                state_nx = S_SR;
            end
            S_SR: begin
                if (!lp_req) state_nx = S_SRX;
            end
            S_SRX: begin
                if (hold_done) state_nx = S_IDLE;
            end
            default: state_nx = S_IDLE;
        endcase
    end

    always_comb begin
        cmd      = CMD_DESEL;
        cke      = 1'b1;
        bus_req  = 1'b1;
        pchg_req = 1'b0;
        busy     = 1'b0;
        unique case (state)
            S_IDLE: begin
                bus_req = 1'b0;
            end
            S_REQ: begin
                cmd = CMD_DESEL;
            end
            S_PRECH: begin
                pchg_req = 1'b1;
            end
            S_AREF: begin
                cmd  = CMD_AREF;
                busy = 1'b1;
            end
            S_ARWAIT: begin
                cmd  = CMD_NOP;
                busy = 1'b1;
            end
            S_SREN: begin
                cmd  = CMD_AREF;
                cke  = 1'b0;
                busy = 1'b1;
            end
            S_SR: begin
                cmd  = CMD_NOP;
                cke  = 1'b0;
                busy = 1'b1;
            end
            S_SRX: begin
                cmd  = CMD_NOP;
                busy = 1'b1;
            end
            default: begin
                bus_req = 1'b0;
            end
        endcase
    end

    assign pins  = encode_cmd(cmd);
    assign cs_n  = pins.cs_n;
    assign ras_n = pins.ras_n;
    assign cas_n = pins.cas_n;
    assign we_n  = pins.we_n;

endmodule

// File: rtl/refresh_sched_checker.sv
module refresh_sched_checker #(
    parameter int unsigned RFC_CYC = 14,
    parameter int unsigned XSR_CYC = 16
) (
    input logic clk,
    input logic rst_n,
    input logic lp_req,
    input logic grant,
    input logic banks_idle,
    input logic bus_req,
    input logic pchg_req,
    input logic cs_n,
    input logic ras_n,
    input logic cas_n,
    input logic we_n,
    input logic cke,
    input logic busy
);
    localparam int unsigned GAP_MAX = (RFC_CYC > XSR_CYC) ? RFC_CYC : XSR_CYC;
    localparam int unsigned GAP_W   = $clog2(GAP_MAX + 1);

    logic is_ar, is_nop, cke_q, cke_rise;
    logic [GAP_W-1:0] ar_gap, x_gap;

    assign is_ar    = !cs_n && !ras_n && !cas_n && we_n;
    assign is_nop   = !cs_n && ras_n && cas_n && we_n;
    assign cke_rise = cke && !cke_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ar_gap <= '0;
            x_gap  <= '0;
            cke_q  <= 1'b1;
        end else begin
            cke_q <= cke;
            if (is_ar && cke)       ar_gap <= GAP_W'(RFC_CYC);
            else if (ar_gap != '0)  ar_gap <= ar_gap - 1'b1;
            if (cke_rise)           x_gap <= GAP_W'(XSR_CYC - 1);
            else if (x_gap != '0)   x_gap <= x_gap - 1'b1;
        end
    end

    // R2: commands only with the bus granted
    p_ar_granted_r2: assert property (@(posedge clk) disable iff (!rst_n)
        is_ar |-> grant);
    p_desel_when_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_req |-> (cs_n && cke));
    // R3: banks idle before any refresh command
    p_ar_banks_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        is_ar |-> banks_idle);
    p_pchg_owner_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pchg_req |-> (bus_req && !busy));
    // R5: NOP-only window after a refresh
    p_nop_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ar_gap != '0) |-> is_nop);
    // R7: CKE falls only with the refresh encoding
    p_sr_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cke) |-> (is_ar && busy));
    // R8: stays in self-refresh while requested
    p_sr_stay_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke && lp_req) |=> !cke);
    p_sr_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke && !cke_q) |-> is_nop);
    // R9: exit hold
    p_exit_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cke_rise || x_gap != '0) |-> (is_nop && busy));
    // R11: busy implies bus ownership
    p_busy_owned_r11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> bus_req);

endmodule

bind refresh_sched refresh_sched_checker #(
    .RFC_CYC (RFC_CYC),
    .XSR_CYC (XSR_CYC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lp_req     (lp_req),
    .grant      (grant),
    .banks_idle (banks_idle),
    .bus_req    (bus_req),
    .pchg_req   (pchg_req),
    .cs_n       (cs_n),
    .ras_n      (ras_n),
    .cas_n      (cas_n),
    .we_n       (we_n),
    .cke        (cke),
    .busy       (busy)
);

// File: tb/refresh_sched_bench.sv
`timescale 1ns/1ps
module refresh_sched_bench;
    localparam int WIN  = 400;
    localparam int ROWS = 8;
    localparam int TICK = WIN / ROWS;
    localparam int RFC  = 4;
    localparam int XSR  = 6;
    localparam int DMAX = 3;

    typedef struct packed {
        bit lp;
        int gw;
        int open;
        int hold;
    } scen_t;

    localparam int NSCN = 5;
    localparam scen_t SCN [NSCN] = '{
        '{1'b0, 3, 0, 0},
        '{1'b0, 0, 4, 0},
        '{1'b0, 2, 6, 0},
        '{1'b1, 0, 0, 10},
        '{1'b1, 3, 5, 8}
    };

    logic clk = 1'b0;
    logic rst_n, lp_req, gnt_ok, banks_idle, grant;
    logic bus_req, pchg_req, cs_n, ras_n, cas_n, we_n, cke, busy;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;
    assign grant = bus_req & gnt_ok;

    refresh_sched #(
        .REF_WINDOW_CYC (WIN),
        .ROW_COUNT      (ROWS),
        .RFC_CYC        (RFC),
        .XSR_CYC        (XSR),
        .DEBT_MAX       (DMAX)
    ) u_refresh_sched (
        .clk(clk), .rst_n(rst_n), .lp_req(lp_req), .grant(grant),
        .banks_idle(banks_idle), .bus_req(bus_req), .pchg_req(pchg_req),
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .cke(cke), .busy(busy)
    );

    function automatic bit is_ar();
        return !cs_n && !ras_n && !cas_n && we_n;
    endfunction
    function automatic bit is_nop();
        return !cs_n && ras_n && cas_n && we_n;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wait_ar(input int maxc, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!is_ar() && n < maxc);
    endtask

    task automatic wait_req(input int maxc, output int n);
        n = 0;
        while (!bus_req && n < maxc) begin
            @(negedge clk);
            n++;
        end
    endtask

    // counts NOP cycles with CKE high, starting at the next negedge
    task automatic count_nops(output int n);
        n = 0;
        for (int k = 0; k < 60; k++) begin
            @(negedge clk);
            if (is_nop() && cke) n++;
            else break;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int n, m, ars, gap;
        bit ok;
        rst_n = 1'b0; lp_req = 1'b0; gnt_ok = 1'b0; banks_idle = 1'b1;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(!bus_req && !pchg_req && !busy, "R10 reset flags", {bus_req, pchg_req, busy}, 0);
        chk(cke && cs_n, "R10 reset pins", {cke, cs_n}, 3);
        rst_n = 1'b1;

        // R1 first request near one interval; R2 deselect before grant
        wait_req(200, n);
        chk(n >= TICK - 2 && n <= TICK + 3, "R1 first request delay", n, TICK);
        chk(cs_n && cke && !busy, "R2 deselect before grant", {cs_n, cke, busy}, 6);
        gnt_ok = 1'b1;
        wait_ar(5, n);
        chk(is_ar(), "R2 refresh after grant", n, 1);
        chk(cke, "R4 refresh with CKE high", cke, 1);
        count_nops(n);
        chk(n == RFC, "R5 NOP hold after refresh", n, RFC);
        chk(!bus_req && cs_n, "R2 bus released", bus_req, 0);
        // R1 exact spacing with grant always given
        wait_ar(200, n);
        m = n;
        wait_ar(200, n);
        chk(n == TICK, "R1 refresh interval", n, TICK);
        count_nops(n);

        // table of scenarios
        for (int i = 0; i < NSCN; i++) begin
            gnt_ok = 1'b0;
            banks_idle = (SCN[i].open == 0);
            lp_req = SCN[i].lp;
            wait_req(200, n);
            chk(bus_req && cs_n, "R2 request raised, deselect", {bus_req, cs_n}, 3);
            ok = 1'b1;
            for (int k = 0; k < SCN[i].gw; k++) begin
                @(negedge clk);
                if (is_ar() || !cke || !bus_req) ok = 1'b0;
            end
            chk(ok, "R2 waits for grant", ok, 1);
            gnt_ok = 1'b1;
            if (SCN[i].open > 0) begin
                ok = 1'b1;
                for (int k = 0; k < SCN[i].open; k++) begin
                    @(negedge clk);
                    if (!pchg_req || is_ar() || !cke) ok = 1'b0;
                end
                chk(ok, "R3 precharge-all before refresh", ok, 1);
                banks_idle = 1'b1;
            end
            wait_ar(6, n);
            chk(is_ar() && busy, "R11 command issued with busy", {is_ar(), busy}, 3);
            if (SCN[i].lp) begin
                chk(!cke, "R7 entry with CKE low", cke, 0);
                ok = 1'b1;
                for (int k = 0; k < SCN[i].hold; k++) begin
                    @(negedge clk);
                    if (cke || !is_nop() || !busy) ok = 1'b0;
                end
                chk(ok, "R8 self-refresh held", ok, 1);
                lp_req = 1'b0;
                count_nops(n);
                chk(n == XSR, "R9 exit NOP hold", n, XSR);
                chk(!busy, "R9 busy released", busy, 0);
            end else begin
                chk(cke, "R4 refresh encoding CKE high", cke, 1);
                count_nops(n);
                chk(n == RFC, "R5 NOP hold", n, RFC);
                chk(!bus_req && cs_n && !busy, "R11 busy and bus released", {bus_req, busy}, 0);
            end
        end

        // R6 debt saturation and burst
        lp_req = 1'b0; banks_idle = 1'b1; gnt_ok = 1'b1;
        repeat (60) @(negedge clk);
        gnt_ok = 1'b0;
        repeat (TICK + 5) begin
            @(negedge clk);
            if (!bus_req) break;
        end
        wait_req(200, n);
        repeat (160) @(negedge clk);
        gnt_ok = 1'b1;
        ars = 0; gap = 0; m = -1;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (is_ar()) begin
                ars++;
                if (ars == 2) gap = k - m;
                m = k;
            end
        end
        chk(ars == DMAX, "R6 saturated burst count", ars, DMAX);
        chk(gap == RFC + 2, "R6 burst spacing", gap, RFC + 2);

        // R7 priority over owed refresh and debt discard
        gnt_ok = 1'b0;
        wait_req(200, n);
        lp_req = 1'b1;
        repeat (2) @(negedge clk);
        gnt_ok = 1'b1;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (cs_n && n < 6);
        chk(is_ar() && !cke, "R7 entry wins over owed refresh", cke, 0);
        repeat (3) @(negedge clk);
        lp_req = 1'b0;
        count_nops(n);
        chk(n == XSR, "R9 exit hold", n, XSR);
        ok = 1'b1;
        for (int k = 0; k < 20; k++) begin
            if (bus_req) ok = 1'b0;
            @(negedge clk);
        end
        chk(ok, "R7 owed refreshes discarded", ok, 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule